// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing command engine of a floppy-style disk controller. A host reaches it through a small register bus with two locations: a read-only status byte and a byte-wide data port. The host writes an opcode to the data port, then the parameter bytes that opcode needs. The block then either starts an external head-positioning unit or goes straight to a result phase, where the host reads back the result bytes. The status byte always shows whether the data port is ready, which way data flows, and whether a command is in progress.

The block handles version query, lock/unlock, timing specification, interrupt sensing, seek and recalibrate. Seek and recalibrate leave through a one-cycle start pulse and come back on a done pulse. Their completion is latched as a pending interrupt, and a later sense-interrupt command reports and clears it. Sector data transfer, the drive cable and the media belong to other blocks.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte (read with `reg_sel`=0) is 0x80. Status bits: bit 7 = ready for a byte, bit 6 = direction (1 = block to host), bit 5 = non-DMA execution, bit 4 = command busy, bits 3:0 = 0. Idle means 0x80.
- R2: While parameter bytes are being collected, the status byte reads 0x90. Parameter counts: specify (0x03) 2, recalibrate (0x07) 1, seek (0x0F) 2; every other opcode takes none.
- R3: During a result phase the status byte reads 0xD0 before each result byte. Reading the last result byte returns the status byte to 0x80 on the next cycle.
- R4: Opcode 0x10 returns the single result byte 0x90.
- R5: Opcodes with bits 6:0 equal to 0x14 set the lock flag to opcode bit 7 and return one byte equal to that flag shifted left by 4 (0x10 or 0x00).
- R6: Specify returns no result bytes and goes back to idle silently. Bit 0 of its second parameter byte becomes the non-DMA flag.
- R7: After the last parameter byte of seek or recalibrate, `pos_start` pulses for exactly one cycle. With it the block presents `pos_recal`, `pos_drive` (bits 1:0 of the first parameter byte) and `pos_cyl` (the second parameter byte for seek, 0 for recalibrate). During execution the status byte is 0x10 with bit 5 equal to the non-DMA flag.
- R8: `pos_done` during execution returns the status byte to 0x80 with no result phase. It latches a pending interrupt together with the drive number and the new cylinder. `pos_done` at any other time has no effect.
- R9: Sense interrupt (0x08) returns two bytes. With an interrupt pending they are 0x20 ORed with the drive number, then the current cylinder. With none pending they are 0x80, then the current cylinder. The opcode clears the pending flag.
- R10: Any other opcode returns the single result byte 0x80 and then goes back to idle.
- R11: Data-port writes during execution or the result phase are ignored. Data-port reads outside the result phase return 0x00 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = status byte, 1 = data port |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (advances result bytes) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from state |
| pos_start | output | 1 | One-cycle start to the head-positioning unit |
| pos_recal | output | 1 | 1 = recalibrate, 0 = seek |
| pos_drive | output | 2 | Target drive |
| pos_cyl | output | 8 | Target cylinder |
| pos_done | input | 1 | Head movement finished |

## Verification
A host data-port write and a head-positioning done pulse can land on the same clock edge during execution. The bench provokes this by raising `reg_wr` and `pos_done` in one cycle after a recalibrate. Its model applies the write rule first (write ignored, because the phase is execution) and then the completion. It judges the outcome by the status byte returning to 0x80 and by a following sense interrupt reporting the recalibrated drive at cylinder 0, with no stray command started by the written byte.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_PARAM, PH_EXEC, PH_RESULT} phase_e;
    typedef enum logic [2:0] {K_VERSION, K_LOCK, K_SPECIFY, K_SENSE,
                              K_SEEK, K_RECAL, K_INVALID} kind_e;

    localparam logic [7:0] OP_VERSION = 8'h10;
    localparam logic [6:0] OP_LOCK7   = 7'h14;
    localparam logic [7:0] OP_SPECIFY = 8'h03;
    localparam logic [7:0] OP_SENSE   = 8'h08;
    localparam logic [7:0] OP_SEEK    = 8'h0F;
    localparam logic [7:0] OP_RECAL   = 8'h07;

    localparam int MSR_RQM  = 7;
    localparam int MSR_DIO  = 6;
    localparam int MSR_NDMA = 5;
    localparam int MSR_BUSY = 4;
endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
    import fdc_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [7:0]       opcode,
    output kind_e            kind,
    output logic [CNT_W-1:0] n_param,
    output logic [CNT_W-1:0] n_result
);
    always_comb begin
        kind     = K_INVALID;
        n_param  = CNT_W'(0);
        n_result = CNT_W'(1);
        if (opcode == OP_VERSION) begin
            kind = K_VERSION;
        end else if (opcode[6:0] == OP_LOCK7) begin
            kind = K_LOCK;
        end else if (opcode == OP_SPECIFY) begin
            kind     = K_SPECIFY;
            n_param  = CNT_W'(2);
            n_result = CNT_W'(0);
        end else if (opcode == OP_SENSE) begin
            kind     = K_SENSE;
            n_result = CNT_W'(2);
        end else if (opcode == OP_SEEK) begin
            kind     = K_SEEK;
            n_param  = CNT_W'(2);
            n_result = CNT_W'(0);
        end else if (opcode == OP_RECAL) begin
            kind     = K_RECAL;
            n_param  = CNT_W'(1);
            n_result = CNT_W'(0);
        end
    end
endmodule

// File: rtl/fdc_result_sel.sv
module fdc_result_sel
    import fdc_seq_pkg::*;
#(
    parameter int         CNT_W      = 2,
    parameter int         DRV_W      = 2,
    parameter logic [7:0] VERSION_ID = 8'h90
) (
    input  kind_e            kind,
    input  logic [CNT_W-1:0] idx,
    input  logic             lock,
    input  logic             sense_hit,
    input  logic [DRV_W-1:0] drive,
    input  logic [7:0]       cyl,
    output logic [7:0]       res_byte
);
    logic [7:0] st0;

    always_comb begin
        st0 = sense_hit ? (8'h20 | 8'(drive)) : 8'h80;
        case (kind)
            K_VERSION: res_byte = VERSION_ID;
            K_LOCK:    res_byte = {3'b000, lock, 4'b0000};
            K_SENSE:   res_byte = (idx == CNT_W'(0)) ? st0 : cyl;
            default:   res_byte = 8'h80;
        endcase
    end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int         DRV_W      = 2,
    parameter logic [7:0] VERSION_ID = 8'h90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             pos_start,
    output logic             pos_recal,
    output logic [DRV_W-1:0] pos_drive,
    output logic [7:0]       pos_cyl,
    input  logic             pos_done
);
    localparam int              CNT_W = 2;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        kind_e            kind;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] n_par;
        logic [CNT_W-1:0] n_res;
        logic [7:0]       p0;
        logic             lock;
        logic             ndma;
        logic             pend;
        logic             sense_hit;
        logic [DRV_W-1:0] drv;
        logic [7:0]       cyl;
        logic [DRV_W-1:0] x_drv;
        logic [7:0]       x_cyl;
        logic             start;
    } state_t;

    state_t q, d;

    logic             fifo_wr, fifo_rd;
    kind_e            dec_kind;
    logic [CNT_W-1:0] dec_np, dec_nr;
    logic [7:0]       res_byte, msr;

    assign fifo_wr = reg_wr & reg_sel;
    assign fifo_rd = reg_rd & reg_sel;

    fdc_op_decode #(.CNT_W(CNT_W)) u_dec (
        .opcode   (reg_wdata),
        .kind     (dec_kind),
        .n_param  (dec_np),
        .n_result (dec_nr)
    );

    fdc_result_sel #(.CNT_W(CNT_W), .DRV_W(DRV_W), .VERSION_ID(VERSION_ID)) u_res (
        .kind      (q.kind),
        .idx       (q.idx),
        .lock      (q.lock),
        .sense_hit (q.sense_hit),
        .drive     (q.drv),
        .cyl       (q.cyl),
        .res_byte  (res_byte)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        case (q.phase)
            PH_IDLE: if (fifo_wr) begin
                d.kind  = dec_kind;
                d.idx   = CNT_W'(0);
                d.n_par = dec_np;
                d.n_res = dec_nr;
                if (dec_kind == K_LOCK) d.lock = reg_wdata[7];
                if (dec_kind == K_SENSE) begin
                    d.sense_hit = q.pend;
                    d.pend      = 1'b0;
                end
                if (dec_np != CNT_W'(0))      d.phase = PH_PARAM;
                else if (dec_nr != CNT_W'(0)) d.phase = PH_RESULT;
            end
            PH_PARAM: if (fifo_wr) begin
                if (q.idx == q.n_par - ONE) begin
                    d.idx   = CNT_W'(0);
                    d.phase = PH_IDLE;
                    case (q.kind)
                        K_SPECIFY: d.ndma = reg_wdata[0];
                        K_RECAL: begin
                            d.x_drv = reg_wdata[DRV_W-1:0];
                            d.x_cyl = 8'h00;
                            d.start = 1'b1;
                            d.phase = PH_EXEC;
                        end
                        K_SEEK: begin
                            d.x_drv = q.p0[DRV_W-1:0];
                            d.x_cyl = reg_wdata;
                            d.start = 1'b1;
                            d.phase = PH_EXEC;
                        end
                        default: ;
                    endcase
                end else begin
                    d.p0  = reg_wdata;
                    d.idx = q.idx + ONE;
                end
            end
            PH_EXEC: if (pos_done) begin
                d.pend  = 1'b1;
                d.drv   = q.x_drv;
                d.cyl   = q.x_cyl;
                d.phase = PH_IDLE;
            end
            PH_RESULT: if (fifo_rd) begin
                if (q.idx == q.n_res - ONE) begin
                    d.idx   = CNT_W'(0);
                    d.phase = PH_IDLE;
                end else begin
                    d.idx = q.idx + ONE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.kind  <= K_INVALID;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        msr = 8'h00;
        case (q.phase)
            PH_IDLE:   msr[MSR_RQM] = 1'b1;
            PH_PARAM: begin
                msr[MSR_RQM]  = 1'b1;
                msr[MSR_BUSY] = 1'b1;
            end
            PH_EXEC: begin
                msr[MSR_BUSY] = 1'b1;
                msr[MSR_NDMA] = q.ndma;
            end
            PH_RESULT: begin
                msr[MSR_RQM]  = 1'b1;
                msr[MSR_DIO]  = 1'b1;
                msr[MSR_BUSY] = 1'b1;
            end
            default: ;
        endcase
    end

    assign reg_rdata = reg_sel ? ((q.phase == PH_RESULT) ? res_byte : 8'h00) : msr;
    assign pos_start = q.start;
    assign pos_recal = (q.kind == K_RECAL);
    assign pos_drive = q.x_drv;
    assign pos_cyl   = q.x_cyl;

    // Start pulse lasts one cycle and the port stops accepting bytes with it
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_start |=> !pos_start);
    assert_exec_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_start |-> (!msr[MSR_RQM] && msr[MSR_BUSY]));
    // Completion goes straight back to idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_EXEC && pos_done) |=> (msr == 8'h80));
    // Last result byte read returns to the command-ready state
    assert_last_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RESULT && fifo_rd && q.idx == q.n_res - ONE) |=> (msr == 8'h80));
    // Host writes cannot disturb execution
    assert_exec_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_EXEC && fifo_wr && !pos_done) |=> (q.phase == PH_EXEC && !pos_start));
endmodule

// File: tb/fdc_cmd_seq_bench.sv
module fdc_cmd_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, done = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       pstart, precal;
    logic [1:0] pdrive;
    logic [7:0] pcyl;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit armed = 1'b0;

    // behavioural reference model
    int         mph = 0;          // 0 idle, 1 params, 2 exec, 3 result
    logic [7:0] resq[$];
    logic [7:0] prm[$];
    logic [7:0] opk = 8'h00;
    int         need = 0;
    bit         lockm = 0, ndmam = 0, pend = 0;
    logic [1:0] drvm = 0, xdrv = 0;
    logic [7:0] cylm = 0, xcyl = 0;
    int         starts = 0, exp_starts = 0;

    always #5 clk = ~clk;

    fdc_cmd_seq u_fdc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wd), .reg_rdata(rdata), .pos_start(pstart), .pos_recal(precal),
        .pos_drive(pdrive), .pos_cyl(pcyl), .pos_done(done)
    );

    task automatic check(int act, int exp, string t);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", t, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_msr();
        case (mph)
            0: return 8'h80;
            1: return 8'h90;
            2: return {2'b00, ndmam, 5'b10000};
            default: return 8'hD0;
        endcase
    endfunction

    task automatic model_write(logic [7:0] b);
        if (mph == 0) begin
            prm.delete();
            opk = b; need = 0;
            if (b == 8'h10) resq.push_back(8'h90);
            else if (b[6:0] == 7'h14) begin lockm = b[7]; resq.push_back({3'b000, lockm, 4'b0000}); end
            else if (b == 8'h08) begin
                resq.push_back(pend ? (8'h20 | {6'b0, drvm}) : 8'h80);
                resq.push_back(cylm);
                pend = 0;
            end
            else if (b == 8'h03 || b == 8'h0F) need = 2;
            else if (b == 8'h07) need = 1;
            else resq.push_back(8'h80);
            mph = (need != 0) ? 1 : ((resq.size() != 0) ? 3 : 0);
        end else if (mph == 1) begin
            prm.push_back(b);
            if (prm.size() == need) begin
                if (opk == 8'h03) begin ndmam = b[0]; mph = 0; end
                else if (opk == 8'h07) begin xdrv = b[1:0]; xcyl = 8'h00; mph = 2; exp_starts++; end
                else begin xdrv = prm[0][1:0]; xcyl = b; mph = 2; exp_starts++; end
            end
        end
    endtask

    task automatic model_done();
        if (mph == 2) begin pend = 1; drvm = xdrv; cylm = xcyl; mph = 0; end
    endtask

    task automatic wr_b(logic [7:0] b);
        @(negedge clk); sel = 1; wr = 1; wd = b;
        @(posedge clk); #1 wr = 0; sel = 0;
        model_write(b);
    endtask

    task automatic rd_b();
        @(negedge clk); sel = 1;
        #1 check(int'(rdata), (mph == 3) ? int'(resq[0]) : 0, {tag, " data"});
        rd = 1;
        @(posedge clk); #1 rd = 0; sel = 0;
        if (mph == 3) begin void'(resq.pop_front()); if (resq.size() == 0) mph = 0; end
    endtask

    task automatic pulse_done(bit with_write, logic [7:0] b);
        @(negedge clk); done = 1;
        if (with_write) begin sel = 1; wr = 1; wd = b; end
        @(posedge clk); #1 done = 0; wr = 0; sel = 0;
        if (with_write) model_write(b);
        model_done();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // status byte compared with the model every cycle
    always @(negedge clk) begin
        #2;
        if (armed && !sel) check(int'(rdata), int'(exp_msr()), {tag, " status"});
    end

    // start pulses compared against the model's target
    always @(negedge clk) begin
        if (armed && pstart) begin
            starts++;
            check(int'({precal, pdrive, pcyl}), int'({opk == 8'h07, xdrv, xcyl}), "R7 start fields");
        end
    end

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog expired actual 0 expected 1");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        check(int'(rdata), 8'h80, "R1 reset status");
        check(int'(pstart), 0, "R1 reset start");
        armed = 1;
        idle(2);

        tag = "R4"; wr_b(8'h10); rd_b();
        tag = "R5"; wr_b(8'h94); rd_b(); wr_b(8'h14); rd_b();
        tag = "R10"; wr_b(8'h55); rd_b();
        tag = "R2 R6"; wr_b(8'h03); idle(2); wr_b(8'hAF); wr_b(8'h07); idle(2);
        tag = "R9 none"; wr_b(8'h08); rd_b(); idle(1); rd_b();

        tag = "R7 seek"; wr_b(8'h0F); wr_b(8'h02); wr_b(8'h27);
        tag = "R11 exec"; wr_b(8'h10); rd_b(); idle(4);
        tag = "R8"; pulse_done(0, 8'h00); idle(2);
        tag = "R9 hit"; wr_b(8'h08); rd_b(); rd_b();

        tag = "R11 result"; wr_b(8'h10); wr_b(8'h08); rd_b(); idle(1);
        tag = "R3"; wr_b(8'h08); rd_b(); rd_b(); rd_b();

        tag = "R6 ndma0"; wr_b(8'h03); wr_b(8'h00); wr_b(8'h00);
        tag = "R7 recal"; wr_b(8'h07); wr_b(8'h01); idle(3);
        tag = "R8 R11 same"; pulse_done(1, 8'h10); idle(2);
        tag = "R9 recal"; wr_b(8'h08); rd_b(); rd_b();
        tag = "R8 stray"; pulse_done(0, 8'h00); idle(1);
        tag = "R9 cleared"; wr_b(8'h08); rd_b(); rd_b();
        idle(2);
        check(starts, exp_starts, "R7 start count");
        finish_up();
    end
endmodule